// File: doc/BRIEF.md
# Nickel-Cell Charge Sequencer

This block sequences a charger for nickel-cadmium and nickel-metal-hydride packs. Comparator flags report the battery voltage against three levels: low limit, maximum cell voltage and power-down. They also report the thermistor voltage against the hot-start fault level and the cutoff level. A slope detector outside the block raises a peak-voltage flag or a negative-delta flag. A 1 ms tick paces every time base. The block drives two open-drain pull controls. The charge pull blocks the current source while it is asserted. The LED pull lights the status lamp while it is asserted.

The sequencer qualifies the pack and then fast charges it. It can follow with a reduced-rate top-off, and it then holds the pack in pulse-trickle indefinitely. A safety timer bounds fast charge, is cleared, and bounds top-off again. The three-level timer-mode code selects the timer limits, the slope test, whether top-off runs and the trickle pulse width. An inhibit input suspends fast charge and top-off without losing the sequencer's place. A battery above the power-down level releases both outputs.

Top module: `nimh_charge_sequencer`

## Requirements
- R1: After reset the sequencer enters fast charge at the first clock edge only when the battery is not below the low limit, not above the maximum cell voltage and the thermistor is not hot; otherwise it pulse-trickles. ccPullLow=0 means charge current flows.
- R2: Fast charge ends when the safety timer reaches the limit for the latched mode, counted in ticks. The mode codes are 00 = low, 01 = mid, 10 = high, and 11 is taken as mid. With a tick on every cycle the LED stays on for limit+1 cycles.
- R3: In low and mid modes pvdFlag ends fast charge and ndvFlag is ignored. In high mode ndvFlag ends it and pvdFlag is ignored.
- R4: A battery above the maximum cell voltage, or a thermistor below the cutoff level, ends fast charge at the next edge.
- R5: Top-off follows fast charge only in modes whose TOPOFF_MASK bit is set (bit 0 = low by default). During top-off, charge flows in the first TOP_ON ticks of every PULSE_PERIOD. Top-off ends only on maximum voltage, cutoff temperature or its own timer, and slope flags are ignored.
- R6: In pulse-trickle, charge flows for the mode's width (low 37, mid 73, high 18 ticks) in every PULSE_PERIOD, with no time limit.
- R7: ledPullLow is asserted only while fast charging, except when inhibit holds it.
- R8: While inhibit is high, the safety timer stops, fast charge and top-off give way to trickle pulses, and the LED keeps its value. The state resumes when inhibit falls. The cutoff temperature still ends fast charge and top-off.
- R9: While the battery is above the power-down level both pull outputs are released. When it drops below, the block pulse-trickles.
- R10: A battery falling below the maximum cell voltage during pulse-trickle starts a new cycle after START_DLY ticks of waiting with charge blocked.
- R11: The mode code is latched when a cycle is qualified, so a later change does not alter the running limits.
- R12: During reset the charge pull is asserted and the LED pull is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | One-cycle pulse every millisecond |
| modeIn | input | 2 | Timer-mode code: 00 low, 01 mid, 10 high |
| batAboveMax | input | 1 | Battery above maximum cell voltage |
| batBelowLow | input | 1 | Battery below low-battery limit |
| batAbovePd | input | 1 | Battery above power-down level |
| tsBelowHtf | input | 1 | Thermistor below hot-start fault level |
| tsBelowTco | input | 1 | Thermistor below temperature cutoff |
| inhibit | input | 1 | Suspend fast charge and top-off |
| pvdFlag | input | 1 | Peak-voltage detect from slope detector |
| ndvFlag | input | 1 | Negative-delta detect from slope detector |
| ccPullLow | output | 1 | Pull charge-control pin low (blocks charge) |
| ledPullLow | output | 1 | Pull LED pin low (lamp on) |

## Verification
The assertions assume that all comparator flags and inhibit are synchronous to clk and already free of glitches. They also assume that a battery above the power-down level is also reported above the maximum cell voltage, and that msTick is a clean pulse. The stimulus changes every input only at falling clock edges and holds msTick high so that one tick is one cycle. It raises batAbovePd only together with batAboveMax and lowers them in the physical order. Slope and temperature flags are pulsed or held only while the sequencer is in the state whose response is being measured.

// File: rtl/chg_seq_pkg.sv
`timescale 1ns/1ps
package chg_seq_pkg;

  typedef enum logic [2:0] {
    ST_PEND = 3'd0,
    ST_FAST = 3'd1,
    ST_TOP  = 3'd2,
    ST_TRKL = 3'd3,
    ST_LPWR = 3'd4
  } chgState_t;

  typedef enum logic [1:0] {
    LIM_DLY  = 2'd0,
    LIM_FAST = 2'd1,
    LIM_TOP  = 2'd2
  } limSel_t;

  typedef struct packed {
    logic    tmrClear;
    logic    tmrRun;
    limSel_t limSel;
    logic    modeLatch;
  } seqStrobe_t;

  localparam logic [1:0] MODE_LOW  = 2'b00;
  localparam logic [1:0] MODE_MID  = 2'b01;
  localparam logic [1:0] MODE_HIGH = 2'b10;

endpackage

// File: rtl/chg_seq_dp.sv
`timescale 1ns/1ps
module chg_seq_dp
  import chg_seq_pkg::*;
#(
  parameter int TMR_W         = 24,
  parameter int FAST_LIM_LOW  = 4800000,
  parameter int FAST_LIM_MID  = 9600000,
  parameter int FAST_LIM_HIGH = 2400000,
  parameter int TOP_LIM_LOW   = 4800000,
  parameter int TOP_LIM_MID   = 9600000,
  parameter int TOP_LIM_HIGH  = 2400000,
  parameter int TRKL_W_LOW    = 37,
  parameter int TRKL_W_MID    = 73,
  parameter int TRKL_W_HIGH   = 18,
  parameter int TOP_ON        = 73,
  parameter int PULSE_PERIOD  = 1170,
  parameter int START_DLY     = 500,
  parameter logic [2:0] TOPOFF_MASK = 3'b001
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic [1:0] modeIn,
  input  seqStrobe_t strb,
  output logic       tmrDone,
  output logic       trickleOn,
  output logic       topoffOn,
  output logic       modeIsHigh,
  output logic       topoffEn
);

  localparam int NMODE = 4;
  localparam int PH_W  = $clog2(PULSE_PERIOD);
  localparam logic [3:0] TOP_MASK4 = {TOPOFF_MASK[1], TOPOFF_MASK};

  logic [1:0]       modeReg;
  logic [PH_W-1:0]  phase;
  logic [TMR_W-1:0] tmrCnt;
  logic [TMR_W-1:0] curLim;

  logic [TMR_W-1:0] fastLim [NMODE];
  logic [TMR_W-1:0] topLim  [NMODE];
  logic [PH_W-1:0]  trklW   [NMODE];

  // per-mode limit tables; index 3 mirrors mid
  generate
    for (genvar m = 0; m < NMODE; m++) begin : g_mode
      localparam int FL = (m == 0) ? FAST_LIM_LOW : (m == 2) ? FAST_LIM_HIGH : FAST_LIM_MID;
      localparam int TL = (m == 0) ? TOP_LIM_LOW  : (m == 2) ? TOP_LIM_HIGH  : TOP_LIM_MID;
      localparam int TW = (m == 0) ? TRKL_W_LOW   : (m == 2) ? TRKL_W_HIGH   : TRKL_W_MID;
      assign fastLim[m] = TMR_W'(FL);
      assign topLim[m]  = TMR_W'(TL);
      assign trklW[m]   = PH_W'(TW);
    end
  endgenerate

  // mode captured at cycle qualification
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= MODE_MID;
    end else if (strb.modeLatch) begin
      modeReg <= (modeIn == 2'b11) ? MODE_MID : modeIn;
    end
  end

  // free-running pulse phase
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
    end else if (msTick) begin
      phase <= (phase == PH_W'(PULSE_PERIOD - 1)) ? '0 : phase + 1'b1;
    end
  end

  // safety / start-up timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrCnt <= '0;
    end else if (strb.tmrClear) begin
      tmrCnt <= '0;
    end else if (strb.tmrRun && msTick && (tmrCnt != '1)) begin
      tmrCnt <= tmrCnt + 1'b1;
    end
  end

  always_comb begin
    case (strb.limSel)
      LIM_DLY: curLim = TMR_W'(START_DLY);
      LIM_TOP: curLim = topLim[modeReg];
      default: curLim = fastLim[modeReg];
    endcase
  end

  assign tmrDone    = (tmrCnt >= curLim);
  assign trickleOn  = (phase < trklW[modeReg]);
  assign topoffOn   = (phase < PH_W'(TOP_ON));
  assign modeIsHigh = (modeReg == MODE_HIGH);
  assign topoffEn   = TOP_MASK4[modeReg];

endmodule

// File: rtl/chg_seq_ctrl.sv
`timescale 1ns/1ps
module chg_seq_ctrl
  import chg_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       batAboveMax,
  input  logic       batBelowLow,
  input  logic       batAbovePd,
  input  logic       tsBelowHtf,
  input  logic       tsBelowTco,
  input  logic       inhibit,
  input  logic       pvdFlag,
  input  logic       ndvFlag,
  input  logic       tmrDone,
  input  logic       trickleOn,
  input  logic       topoffOn,
  input  logic       modeIsHigh,
  input  logic       topoffEn,
  output seqStrobe_t strb,
  output logic       ccPullLow,
  output logic       ledPullLow,
  output chgState_t  curState
);

  chgState_t state, nxt;
  logic maxPrev;
  logic needDelay;
  logic ledReg;
  logic maxFall;
  logic slopeHit;
  logic delayOk;
  logic chargeOn;
  chgState_t afterFast;

  assign maxFall   = maxPrev && !batAboveMax;
  assign slopeHit  = modeIsHigh ? ndvFlag : pvdFlag;
  assign delayOk   = !needDelay || tmrDone;
  assign afterFast = topoffEn ? ST_TOP : ST_TRKL;

  always_comb begin
    nxt = state;
    if (batAbovePd) begin
      nxt = ST_LPWR;
    end else begin
      case (state)
        ST_PEND: begin
          if (delayOk) begin
            if (batAboveMax || batBelowLow || tsBelowHtf) nxt = ST_TRKL;
            else                                          nxt = ST_FAST;
          end
        end
        ST_FAST: begin
          if (tsBelowTco)                                       nxt = afterFast;
          else if (!inhibit && (batAboveMax || tmrDone || slopeHit)) nxt = afterFast;
        end
        ST_TOP: begin
          if (tsBelowTco)                              nxt = ST_TRKL;
          else if (!inhibit && (batAboveMax || tmrDone)) nxt = ST_TRKL;
        end
        ST_TRKL: begin
          if (maxFall) nxt = ST_PEND;
        end
        ST_LPWR: nxt = ST_TRKL;
        default: nxt = ST_PEND;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_PEND;
      maxPrev   <= 1'b0;
      needDelay <= 1'b0;
      ledReg    <= 1'b0;
    end else begin
      state   <= nxt;
      maxPrev <= batAboveMax;
      if (state == ST_TRKL && nxt == ST_PEND) needDelay <= 1'b1;
      if (nxt == ST_LPWR)  ledReg <= 1'b0;
      else if (!inhibit)   ledReg <= (nxt == ST_FAST);
    end
  end

  always_comb begin
    strb.tmrClear  = (state != nxt);
    strb.tmrRun    = (state == ST_PEND) ||
                     (((state == ST_FAST) || (state == ST_TOP)) && !inhibit);
    strb.limSel    = (state == ST_PEND) ? LIM_DLY :
                     (state == ST_TOP)  ? LIM_TOP : LIM_FAST;
    strb.modeLatch = (state == ST_PEND) && (nxt != ST_PEND) && (nxt != ST_LPWR);
  end

  always_comb begin
    case (state)
      ST_FAST: chargeOn = inhibit ? trickleOn : 1'b1;
      ST_TOP:  chargeOn = inhibit ? trickleOn : topoffOn;
      ST_TRKL: chargeOn = trickleOn;
      default: chargeOn = 1'b0;
    endcase
  end

  assign ccPullLow  = (state == ST_LPWR) ? 1'b0 : !chargeOn;
  assign ledPullLow = ledReg;
  assign curState   = state;

endmodule

// File: rtl/nimh_charge_sequencer.sv
`timescale 1ns/1ps
module nimh_charge_sequencer
  import chg_seq_pkg::*;
#(
  parameter int TMR_W         = 24,
  parameter int FAST_LIM_LOW  = 4800000,
  parameter int FAST_LIM_MID  = 9600000,
  parameter int FAST_LIM_HIGH = 2400000,
  parameter int TOP_LIM_LOW   = 4800000,
  parameter int TOP_LIM_MID   = 9600000,
  parameter int TOP_LIM_HIGH  = 2400000,
  parameter int TRKL_W_LOW    = 37,
  parameter int TRKL_W_MID    = 73,
  parameter int TRKL_W_HIGH   = 18,
  parameter int TOP_ON        = 73,
  parameter int PULSE_PERIOD  = 1170,
  parameter int START_DLY     = 500,
  parameter logic [2:0] TOPOFF_MASK = 3'b001
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic [1:0] modeIn,
  input  logic       batAboveMax,
  input  logic       batBelowLow,
  input  logic       batAbovePd,
  input  logic       tsBelowHtf,
  input  logic       tsBelowTco,
  input  logic       inhibit,
  input  logic       pvdFlag,
  input  logic       ndvFlag,
  output logic       ccPullLow,
  output logic       ledPullLow
);

  seqStrobe_t strb;
  chgState_t  curState;
  logic tmrDone, trickleOn, topoffOn, modeIsHigh, topoffEn;

  chg_seq_dp #(
    .TMR_W(TMR_W),
    .FAST_LIM_LOW(FAST_LIM_LOW), .FAST_LIM_MID(FAST_LIM_MID), .FAST_LIM_HIGH(FAST_LIM_HIGH),
    .TOP_LIM_LOW(TOP_LIM_LOW),   .TOP_LIM_MID(TOP_LIM_MID),   .TOP_LIM_HIGH(TOP_LIM_HIGH),
    .TRKL_W_LOW(TRKL_W_LOW),     .TRKL_W_MID(TRKL_W_MID),     .TRKL_W_HIGH(TRKL_W_HIGH),
    .TOP_ON(TOP_ON), .PULSE_PERIOD(PULSE_PERIOD), .START_DLY(START_DLY),
    .TOPOFF_MASK(TOPOFF_MASK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .msTick(msTick), .modeIn(modeIn), .strb(strb),
    .tmrDone(tmrDone), .trickleOn(trickleOn), .topoffOn(topoffOn),
    .modeIsHigh(modeIsHigh), .topoffEn(topoffEn)
  );

  chg_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .batAboveMax(batAboveMax), .batBelowLow(batBelowLow), .batAbovePd(batAbovePd),
    .tsBelowHtf(tsBelowHtf), .tsBelowTco(tsBelowTco), .inhibit(inhibit),
    .pvdFlag(pvdFlag), .ndvFlag(ndvFlag),
    .tmrDone(tmrDone), .trickleOn(trickleOn), .topoffOn(topoffOn),
    .modeIsHigh(modeIsHigh), .topoffEn(topoffEn),
    .strb(strb), .ccPullLow(ccPullLow), .ledPullLow(ledPullLow), .curState(curState)
  );

endmodule

// File: rtl/chg_seq_checker.sv
`timescale 1ns/1ps
module chg_seq_checker
  import chg_seq_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      inhibit,
  input logic      batAbovePd,
  input logic      batAboveMax,
  input logic      tsBelowTco,
  input logic      ccPullLow,
  input logic      ledPullLow,
  input chgState_t state
);

  logic armed;
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  AST_PEND_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PEND) |-> ccPullLow);  // R1

  AST_LPWR_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    batAbovePd |=> (!ccPullLow && !ledPullLow));  // R9

  AST_LED_FAST_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(inhibit)) |-> (ledPullLow == (state == ST_FAST)));  // R7

  AST_INH_LED_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (armed && inhibit && !batAbovePd) |=> $stable(ledPullLow));  // R8

  AST_INH_HOLD_FAST: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FAST && inhibit && !tsBelowTco && !batAbovePd) |=> (state == ST_FAST));  // R8

  AST_TRKL_NO_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (armed && state == ST_TRKL && !batAbovePd && !($past(batAboveMax) && !batAboveMax))
      |=> (state == ST_TRKL));  // R6

endmodule

bind nimh_charge_sequencer chg_seq_checker u_chk (
  .clk(clk), .rstN(rstN), .inhibit(inhibit), .batAbovePd(batAbovePd),
  .batAboveMax(batAboveMax), .tsBelowTco(tsBelowTco),
  .ccPullLow(ccPullLow), .ledPullLow(ledPullLow), .state(curState)
);

// File: tb/tb_nimh_charge_sequencer.sv
`timescale 1ns/1ps
module tb_nimh_charge_sequencer;

  localparam int FL_LOW = 2000, FL_MID = 2500, FL_HIGH = 1500;
  localparam int TL = 3000;
  localparam int PER = 1170;
  localparam int DLY = 400;
  localparam int NVEC = 7;
  // {batBelowLow, batAboveMax, tsBelowHtf, mode[1:0], expectFast}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b000_01_1, 6'b000_00_1, 6'b000_10_1, 6'b000_11_1,
    6'b100_01_0, 6'b010_01_0, 6'b001_01_0
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b1;
  logic [1:0] modeIn = 2'b01;
  logic batAboveMax = 1'b0, batBelowLow = 1'b0, batAbovePd = 1'b0;
  logic tsBelowHtf = 1'b0, tsBelowTco = 1'b0, inhibit = 1'b0;
  logic pvdFlag = 1'b0, ndvFlag = 1'b0;
  logic ccPullLow, ledPullLow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nimh_charge_sequencer #(
    .FAST_LIM_LOW(FL_LOW), .FAST_LIM_MID(FL_MID), .FAST_LIM_HIGH(FL_HIGH),
    .TOP_LIM_LOW(TL), .TOP_LIM_MID(TL), .TOP_LIM_HIGH(TL),
    .START_DLY(DLY)
  ) dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .modeIn(modeIn),
    .batAboveMax(batAboveMax), .batBelowLow(batBelowLow), .batAbovePd(batAbovePd),
    .tsBelowHtf(tsBelowHtf), .tsBelowTco(tsBelowTco), .inhibit(inhibit),
    .pvdFlag(pvdFlag), .ndvFlag(ndvFlag),
    .ccPullLow(ccPullLow), .ledPullLow(ledPullLow)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearIn();
    batAboveMax = 0; batBelowLow = 0; batAbovePd = 0;
    tsBelowHtf = 0; tsBelowTco = 0; inhibit = 0; pvdFlag = 0; ndvFlag = 0;
  endtask

  task automatic doReset(input logic [1:0] m);
    @(negedge clk);
    rstN = 0;
    modeIn = m;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  task automatic ledLowRun(input int pre, output int n);
    n = pre;
    @(negedge clk);
    while (ledPullLow && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic duty(output int on);
    on = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (!ccPullLow) on++;
    end
  endtask

  task automatic waitLed(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!ledPullLow && k < 5000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, on, k;
    clearIn();
    repeat (3) @(negedge clk);
    check("R12 reset cc pulled", int'(ccPullLow), 1);
    check("R12 reset led released", int'(ledPullLow), 0);

    // qualification table: R1, R7
    for (int v = 0; v < NVEC; v++) begin
      clearIn();
      batBelowLow = VEC[v][5];
      batAboveMax = VEC[v][4];
      tsBelowHtf  = VEC[v][3];
      doReset(VEC[v][2:1]);
      repeat (2) @(negedge clk);
      check($sformatf("R1 R7 vec%0d led", v), int'(ledPullLow), int'(VEC[v][0]));
      if (VEC[v][0]) check($sformatf("R1 vec%0d cc", v), int'(ccPullLow), 0);
    end

    // R2 mid expiry, then R6 trickle width with no limit
    clearIn();
    doReset(2'b01);
    ledLowRun(0, n);
    check("R2 mid fast length", n, FL_MID + 1);
    duty(on);
    check("R6 mid trickle width", on, 73);
    repeat (5000) @(negedge clk);
    duty(on);
    check("R6 trickle persists", on, 73);
    check("R7 led off in trickle", int'(ledPullLow), 0);

    // R3 high mode: pvd ignored, ndv ends
    clearIn();
    doReset(2'b10);
    repeat (20) @(negedge clk);
    pvdFlag = 1; @(negedge clk); pvdFlag = 0;
    repeat (3) @(negedge clk);
    check("R3 pvd ignored high", int'(ledPullLow), 1);
    ndvFlag = 1; @(negedge clk); ndvFlag = 0;
    @(negedge clk);
    check("R3 ndv ends high", int'(ledPullLow), 0);

    // R3 ndv ignored in low mode, pvd ends; R5 top-off ignores slope
    clearIn();
    doReset(2'b00);
    repeat (20) @(negedge clk);
    ndvFlag = 1; @(negedge clk); ndvFlag = 0;
    repeat (3) @(negedge clk);
    check("R3 ndv ignored low", int'(ledPullLow), 1);
    pvdFlag = 1; @(negedge clk);
    @(negedge clk);
    check("R3 pvd ends low", int'(ledPullLow), 0);
    duty(on);
    pvdFlag = 0;
    check("R5 topoff duty", on, 73);
    repeat (2500) @(negedge clk);
    duty(on);
    check("R6 low trickle after topoff", on, 37);

    // R5 top-off ends on cutoff temperature
    clearIn();
    doReset(2'b00);
    repeat (20) @(negedge clk);
    pvdFlag = 1; @(negedge clk); pvdFlag = 0;
    repeat (5) @(negedge clk);
    tsBelowTco = 1; repeat (2) @(negedge clk); tsBelowTco = 0;
    repeat (2) @(negedge clk);
    duty(on);
    check("R5 topoff ends on temp", on, 37);

    // R4 max voltage, then R10 replacement delay
    clearIn();
    doReset(2'b01);
    repeat (20) @(negedge clk);
    batAboveMax = 1;
    repeat (2) @(negedge clk);
    check("R4 maxV ends fast", int'(ledPullLow), 0);
    repeat (50) @(negedge clk);
    batAboveMax = 0;
    waitLed(k);
    check("R10 start delay", k, DLY + 2);

    // R4 cutoff temperature
    clearIn();
    doReset(2'b01);
    repeat (20) @(negedge clk);
    tsBelowTco = 1; @(negedge clk); tsBelowTco = 0;
    @(negedge clk);
    check("R4 temp ends fast", int'(ledPullLow), 0);

    // R8 inhibit freezes timer and suspends fast charge
    clearIn();
    doReset(2'b01);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (ledPullLow) n++;
    end
    inhibit = 1;
    on = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (ledPullLow) n++;
      if (!ccPullLow) on++;
    end
    inhibit = 0;
    check("R8 no fast current under inhibit", on, 0);
    ledLowRun(n, n);
    check("R8 timer frozen", n, FL_MID + 1 + 300);

    // R8 temperature acts under inhibit, LED frozen
    clearIn();
    doReset(2'b01);
    repeat (20) @(negedge clk);
    inhibit = 1;
    repeat (5) @(negedge clk);
    tsBelowTco = 1; repeat (3) @(negedge clk); tsBelowTco = 0;
    repeat (20) @(negedge clk);
    check("R8 led frozen", int'(ledPullLow), 1);
    inhibit = 0;
    repeat (2) @(negedge clk);
    check("R8 temp ended fast", int'(ledPullLow), 0);

    // R9 low power, then trickle, then new cycle
    clearIn();
    doReset(2'b01);
    repeat (20) @(negedge clk);
    batAboveMax = 1; batAbovePd = 1;
    repeat (2) @(negedge clk);
    on = 0; k = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (ccPullLow) on++;
      if (ledPullLow) k++;
    end
    check("R9 cc released", on, 0);
    check("R9 led released", k, 0);
    batAbovePd = 0;
    repeat (2) @(negedge clk);
    duty(on);
    check("R9 trickle after power-down", on, 73);
    batAboveMax = 0;
    waitLed(k);
    check("R10 start delay after power-down", k, DLY + 2);

    // R11 mode latched at cycle start
    clearIn();
    doReset(2'b01);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (ledPullLow) n++;
    end
    modeIn = 2'b10;
    ledLowRun(n, n);
    check("R11 limit kept", n, FL_MID + 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule